// File: doc/BRIEF.md
# Sequenced Two-Condition Event Trigger

This block watches a vector of sampled channel levels and produces a single-cycle trigger pulse when a two-stage sequence completes. Two pattern conditions, A and B, are each built from a per-channel value and a per-channel care bit. A channel whose care bit is 0 does not take part. Each condition produces events either when its pattern starts to match or when it stops matching. Event A arms the sequencer. Event B then completes the sequence in one of two ways.

In count mode the trigger fires on the Nth B event after arming. In delay mode the block first waits a programmed number of clock cycles measured from the A event, then fires on the first B event. An external gate input, with a selectable active level, decides whether events are recognised at all. A synchronous clear, or any change of the configuration inputs, returns the sequencer to idle.

Top module: `seq_trigger`

## Requirements
- R1: While reset is asserted, `trig` is 0. In the first clock cycle after reset, no A or B event is recognised, even if a pattern already matches.
- R2: A condition matches when every channel whose care bit is 1 equals its value bit. A channel whose care bit is 0 has no effect on the match.
- R3: With the exit flag at 0, an event occurs in a cycle where the match is 1 and was 0 in the previous cycle. With the exit flag at 1, an event occurs where the match is 0 and was 1 in the previous cycle.
- R4: With `mode`=0 (count mode), `trig` is high for exactly one cycle, in the cycle after the edge where the Nth B event after the A event is seen. A B event in the same cycle as the arming A event is not counted. A `count_n` of 0 acts as 1.
- R5: B events seen while the sequencer is idle are ignored. After a trigger, the sequencer is idle again and needs a new A event.
- R6: An A event that arrives while the sequencer is armed does not restart the count or the delay.
- R7: With `mode`=1 (delay mode), a B event seen k cycles after the arming A event is accepted only if k >= `delay_cyc`; the bound is inclusive. Only the first accepted B event fires.
- R8: A and B events are recognised only while `gate_in` equals `gate_pol`, so `gate_pol`=1 means active high. A trigger is never issued in a cycle after the gate was inactive.
- R9: `clr`=1 at a clock edge returns the sequencer to idle and suppresses a trigger at that edge.
- R10: A change in any configuration input (patterns, care bits, exit flags, `mode`, `count_n`, `delay_cyc`, `gate_pol`) returns the sequencer to idle at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous sequencer clear |
| chan | input | CH | Sampled channel levels |
| a_val | input | CH | Condition A value per channel |
| a_care | input | CH | Condition A care mask (1 = compare) |
| a_exit | input | 1 | Condition A: 0 entry, 1 exit |
| b_val | input | CH | Condition B value per channel |
| b_care | input | CH | Condition B care mask (1 = compare) |
| b_exit | input | 1 | Condition B: 0 entry, 1 exit |
| mode | input | 1 | 0 count mode, 1 delay mode |
| count_n | input | CW | B events needed in count mode |
| delay_cyc | input | DW | Delay after A in clock cycles |
| gate_in | input | 1 | External gate |
| gate_pol | input | 1 | Gate active level |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
Count mode is driven with B events that arrive before A, after A, and interleaved with repeated A events. This separates a correct arming and counting sequencer from one that counts idle B events or restarts on every A. Delay mode places B events one cycle before the delay expires, exactly at expiry and after it, which pins down the inclusive bound. Channel vectors that toggle don't-care bits, or that break only a single cared bit, show whether the mask is honoured. Gate, clear and configuration-change sequences each cut a partly completed sequence short, so that a block ignoring them would fire where the bench expects silence.

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int CH = 8,
  parameter int CW = 27,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CH-1:0] chan,
  input  logic [CH-1:0] a_val,
  input  logic [CH-1:0] a_care,
  input  logic          a_exit,
  input  logic [CH-1:0] b_val,
  input  logic [CH-1:0] b_care,
  input  logic          b_exit,
  input  logic          mode,
  input  logic [CW-1:0] count_n,
  input  logic [DW-1:0] delay_cyc,
  input  logic          gate_in,
  input  logic          gate_pol,
  output logic          trig
);
  localparam int CFGW = 4*CH + 4 + CW + DW;

  logic [CFGW-1:0] cfg, cfg_q;
  logic            primed, prev_a, prev_b, armed;
  logic            hit_a, hit_b, gate_ok, cfg_chg, ev_a, ev_b;
  logic            cnt_done, dly_done, fire, flush;
  logic [CW-1:0]   cnt;
  logic [CW:0]     cnt_next;
  logic [DW-1:0]   tmr;

  assign cfg      = {a_val, a_care, b_val, b_care, a_exit, b_exit, mode, gate_pol, count_n, delay_cyc};
  assign hit_a    = &((chan ~^ a_val) | ~a_care);
  assign hit_b    = &((chan ~^ b_val) | ~b_care);
  assign gate_ok  = (gate_in == gate_pol);
  assign cfg_chg  = primed && (cfg != cfg_q);
  assign flush    = clr | cfg_chg;

  assign ev_a = primed & gate_ok & (a_exit ? (prev_a & ~hit_a) : (hit_a & ~prev_a));
  assign ev_b = primed & gate_ok & (b_exit ? (prev_b & ~hit_b) : (hit_b & ~prev_b));

  assign cnt_next = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
  assign cnt_done = cnt_next >= {1'b0, count_n};
  assign dly_done = tmr >= delay_cyc;
  assign fire     = armed & ev_b & (mode ? dly_done : cnt_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      cfg_q  <= '0;
      armed  <= 1'b0;
      cnt    <= '0;
      tmr    <= '0;
      trig   <= 1'b0;
    end else begin
      primed <= 1'b1;
      prev_a <= hit_a;
      prev_b <= hit_b;
      cfg_q  <= cfg;
      trig   <= fire & ~flush;
      if (flush) begin
        armed <= 1'b0;
        cnt   <= '0;
        tmr   <= '0;
      end else if (!armed) begin
        if (ev_a) begin
          armed <= 1'b1;
          cnt   <= '0;
          tmr   <= DW'(1);
        end
      end else if (fire) begin
        armed <= 1'b0;
      end else begin
        if (ev_b && !mode) cnt <= cnt_next[CW-1:0];
        if (!dly_done) tmr <= tmr + DW'(1);
      end
    end
  end
endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic gate_in,
  input logic gate_pol,
  input logic cfg_chg,
  input logic armed,
  input logic trig
);
  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !trig);

  assert_trig_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  assert_fire_only_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed));

  assert_fire_leaves_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed);

  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(gate_in == gate_pol));

  assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!armed && !trig));

  assert_cfg_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!armed && !trig));
endmodule

bind seq_trigger seq_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .gate_in(gate_in), .gate_pol(gate_pol),
  .cfg_chg(cfg_chg), .armed(armed), .trig(trig)
);

// File: tb/seq_trigger_tb.sv
`timescale 1ns/1ps
module seq_trigger_tb;
  localparam int CH = 8, CW = 27, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic [CH-1:0] chan = 8'h01;
  logic [CH-1:0] a_val = 8'h01, a_care = 8'h03, b_val = 8'h08, b_care = 8'h08;
  logic a_exit = 1'b0, b_exit = 1'b0, mode = 1'b0, gate_in = 1'b1, gate_pol = 1'b1;
  logic [CW-1:0] count_n = CW'(1);
  logic [DW-1:0] delay_cyc = '0;
  logic trig;

  int checks = 0, fails = 0;
  bit done = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  seq_trigger #(.CH(CH), .CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .chan(chan),
    .a_val(a_val), .a_care(a_care), .a_exit(a_exit),
    .b_val(b_val), .b_care(b_care), .b_exit(b_exit),
    .mode(mode), .count_n(count_n), .delay_cyc(delay_cyc),
    .gate_in(gate_in), .gate_pol(gate_pol), .trig(trig));

  task automatic step(input logic [CH-1:0] c, input bit e, input string tag);
    chan = c;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (trig !== e) begin
          fails++;
          $display("FAIL %s: trig=%b expected=%b at %0t", t, trig, e, $time);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    #3;
    checks++;
    if (trig !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: trig=%b expected=0", trig);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Phase 0: N=1, entry on both; A already matching at reset release
    step(8'h01, 0, "R1 first cycle no event");
    step(8'h09, 0, "R1 A not seen at release, R5 idle B ignored");
    step(8'h08, 0, "R5 idle");
    step(8'h0A, 0, "R2 cared bit1 high blocks A");
    step(8'h0B, 0, "R2 bit1 high still blocks A");
    step(8'h00, 0, "R3 idle");
    step(8'h01, 0, "R3 A entry arms");
    step(8'h09, 1, "R4 N=1 fires");
    step(8'h01, 0, "R4 single-cycle pulse");

    // Phase 1: N=3, don't-care bits toggled
    count_n = CW'(3);
    step(8'h00, 0, "R10 config change");
    step(8'h75, 0, "R2 A with don't-care bits");
    step(8'h7D, 0, "R4 B1");
    step(8'hF5, 0, "R4 B exit no event");
    step(8'h7D, 0, "R4 B2");
    step(8'h75, 0, "R4");
    step(8'hFD, 1, "R4 B3 fires");
    step(8'h75, 0, "R5 back to idle");
    step(8'h7D, 0, "R5 B while idle ignored");
    step(8'h75, 0, "R5");
    step(8'h00, 0, "R6");
    step(8'h01, 0, "R6 A arms");
    step(8'h09, 0, "R6 B1");
    step(8'h00, 0, "R6 A exit");
    step(8'h01, 0, "R6 A again while armed");
    step(8'h09, 0, "R6 B2");
    step(8'h01, 0, "R6");
    step(8'h09, 1, "R6 B3 fires, no restart");

    // Phase 2: B on exit, N=2
    count_n = CW'(2);
    b_exit = 1'b1;
    step(8'h00, 0, "R10 config change");
    step(8'h01, 0, "R3 A entry");
    step(8'h09, 0, "R3 B entry not an event");
    step(8'h01, 0, "R3 B exit 1");
    step(8'h09, 0, "R3");
    step(8'h01, 1, "R3 B exit 2 fires");
    step(8'h00, 0, "R10");
    step(8'h01, 0, "R10 A arms");
    step(8'h09, 0, "R10");
    step(8'h01, 0, "R10 B exit 1");
    delay_cyc = DW'(5);
    step(8'h01, 0, "R10 config change clears");
    step(8'h09, 0, "R10");
    step(8'h01, 0, "R10 B exit after change ignored");
    step(8'h09, 0, "R10");
    step(8'h01, 0, "R10 still idle");
    step(8'h00, 0, "R9");
    step(8'h01, 0, "R9 A arms");
    step(8'h09, 0, "R9");
    step(8'h01, 0, "R9 B exit 1");
    clr = 1'b1;
    step(8'h09, 0, "R9 clear");
    clr = 1'b0;
    step(8'h01, 0, "R9 B exit after clear ignored");
    step(8'h00, 0, "R9");
    step(8'h01, 0, "R9 A rearms");
    step(8'h09, 0, "R9");
    step(8'h01, 0, "R9 B exit 1");
    step(8'h09, 0, "R9");
    step(8'h01, 1, "R9 B exit 2 fires");

    // Phase 3: delay mode, delay 4, entry
    mode = 1'b1;
    b_exit = 1'b0;
    delay_cyc = DW'(4);
    step(8'h00, 0, "R10 config change");
    step(8'h01, 0, "R7 A arms k0");
    step(8'h09, 0, "R7 B at k1 rejected");
    step(8'h01, 0, "R7 k2");
    step(8'h09, 0, "R7 B at k3 rejected");
    step(8'h01, 0, "R7 k4");
    step(8'h09, 1, "R7 B at k5 fires");
    step(8'h00, 0, "R7");
    step(8'h01, 0, "R7 A arms k0");
    step(8'h01, 0, "R7 k1");
    step(8'h01, 0, "R7 k2");
    step(8'h01, 0, "R7 k3");
    step(8'h09, 1, "R7 B at k=delay fires");
    step(8'h01, 0, "R7 only first B");
    step(8'h09, 0, "R7 idle after fire");

    // Phase 4: gate active low, count N=1
    mode = 1'b0;
    count_n = CW'(1);
    gate_pol = 1'b0;
    gate_in = 1'b1;
    step(8'h00, 0, "R10 config change");
    step(8'h01, 0, "R8 A while gate inactive ignored");
    step(8'h09, 0, "R8 B while gate inactive");
    step(8'h01, 0, "R8");
    gate_in = 1'b0;
    step(8'h09, 0, "R8 not armed since A was gated");
    step(8'h01, 0, "R8");
    step(8'h00, 0, "R8");
    step(8'h01, 0, "R8 A arms with gate active");
    gate_in = 1'b1;
    step(8'h09, 0, "R8 B while gate inactive no fire");
    gate_in = 1'b0;
    step(8'h01, 0, "R8");
    step(8'h09, 1, "R8 B with gate active fires");
    step(8'h01, 0, "R8");

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule